// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block takes interrupts that arrive over a system bus, each aimed at one CPU and each carrying a 5-bit source identifier and two 64-bit data words. Every CPU owns one mailbox. A mailbox holds a busy flag, the source identifier of the last accepted interrupt, and its two data words. An interrupt for a CPU whose mailbox is free is taken in the cycle it is offered. Its payload is stored, the mailbox turns busy, and the block posts one programmable vector to that CPU. That vector is shared by every mailbox. An interrupt for a busy mailbox is refused in the same cycle, and the sender has to offer it again later.

Software reaches the mailboxes through a small register window. Each CPU has its own slots for data word 0, data word 1 and status, spaced 8 bytes apart. Three alias slots reach the mailbox of whichever CPU is making the access, so a handler can find its own mailbox without knowing its CPU number. A handler releases its mailbox by writing zero into the busy bit of the status register.

Top module: `cpu_irq_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every mailbox is free, the shared vector is 0, and every register reads as 0.
- R2: When an interrupt is offered to a free mailbox, `irq_accept` goes high in the same cycle. In that cycle `post_valid` is high, `post_cpu` equals `irq_cpu` and `post_vector` equals the vector register's value before any write in that cycle. `irq_accept` and `irq_retry` are both low when nothing is offered.
- R3: When an interrupt is offered to a busy mailbox, `irq_retry` goes high in the same cycle, nothing is posted, and the mailbox contents stay as they were.
- R4: An accepted interrupt sets that mailbox's busy flag and stores its source identifier and both data words. All of these are visible from the next cycle on.
- R5: When a status-register write and an offered interrupt target the same mailbox in the same cycle, the interrupt is refused with `irq_retry` and the write takes effect.
- R6: The shared vector register is at byte offset 0x318 (word 3N+3 for N CPU slots). A write loads data bits 5:0, and a read returns the vector in bits 5:0 with every other bit 0.
- R7: The indexed registers for CPU i are at byte offsets 8*i (data word 0), 8*(N+i) (data word 1) and 8*(2N+i) (status), with N = 32 by default. A status read returns busy in bit 5, the source identifier in bits 4:0, and 0 in all other bits. Address bits 2:0 are ignored.
- R8: The alias registers at 0x300 (data word 0), 0x308 (data word 1) and 0x310 (status) access the mailbox of the CPU numbered by `reg_cpu_id`.
- R9: A write to a status register, indexed or alias, loads the busy flag from data bit 5 and so can either set or clear it. The stored source identifier is left unchanged. Writes to data-word registers and to unmapped offsets change nothing.
- R10: Every read returns `reg_rdata` together with `reg_rvalid` one cycle after the request, and `reg_rvalid` is low in every other cycle. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_valid | input | 1 | An interrupt is offered this cycle |
| irq_cpu | input | 5 | CPU the offered interrupt is aimed at |
| irq_src | input | 5 | Source identifier of the offered interrupt |
| irq_data0 | input | 64 | First data word of the offered interrupt |
| irq_data1 | input | 64 | Second data word of the offered interrupt |
| irq_accept | output | 1 | Interrupt taken this cycle |
| irq_retry | output | 1 | Interrupt refused this cycle; sender must offer it again |
| post_valid | output | 1 | Vector posted to a CPU this cycle |
| post_cpu | output | 5 | CPU receiving the posted vector |
| post_vector | output | 6 | Posted vector |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_cpu_id | input | 5 | Number of the CPU making the access (used by alias slots) |
| reg_rdata | output | 64 | Read data, one cycle after the read request |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The hardest case to reach is the same-cycle collision. It needs an interrupt offered to a mailbox while software writes that mailbox's status register, through either the indexed slot or the alias slot. Random traffic alone seldom lines up on the same mailbox. The stimulus therefore confines most interrupt targets to four CPUs, aims a large share of the random status writes at the CPU being offered an interrupt in that cycle, and adds directed collisions through both paths. Busy mailboxes being re-offered interrupts, and releases that clear busy and then let the next offer through, come up repeatedly for the same reason.

// File: rtl/cim_pkg.sv
// Package: shared selector type and field positions for the interrupt mailbox.
// Assumes the source identifier fits below the busy bit of the status word.
package cim_pkg;

    // Which piece of mailbox state a register access resolves to.
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_D0   = 3'd1,
        SEL_D1   = 3'd2,
        SEL_BUSY = 3'd3,
        SEL_VEC  = 3'd4
    } sel_kind_t;

    // Status word layout: busy flag position; the source sits in the bits below.
    localparam int BUSY_BIT = 5;

    // Region codes carried by the two word-index bits above the CPU index.
    localparam logic [1:0] REG_D0    = 2'd0;
    localparam logic [1:0] REG_D1    = 2'd1;
    localparam logic [1:0] REG_BUSY  = 2'd2;
    localparam logic [1:0] REG_ALIAS = 2'd3;

    // Slot numbers inside the alias region.
    localparam int ALIAS_D0   = 0;
    localparam int ALIAS_D1   = 1;
    localparam int ALIAS_BUSY = 2;
    localparam int ALIAS_VEC  = 3;

endpackage

// File: rtl/cim_reg_decode.sv
// Module: cim_reg_decode
// Turns a register access (byte offset plus the accessing CPU's number) into
// a selector and a mailbox index. The word index splits into a 2-bit region
// and a CPU_W-bit slot. Indexed regions take the slot as the mailbox number.
// The alias region takes the accessing CPU's number instead.
// Assumes NUM_CPUS >= 4 so the alias region has room for its four slots.
// Out-of-range mailbox numbers decode to SEL_NONE.
module cim_reg_decode
    import cim_pkg::*;
#(
    parameter int NUM_CPUS = 32,
    parameter int CPU_W    = $clog2(NUM_CPUS),
    parameter int ADDR_W   = CPU_W + 5
) (
    input  logic              reg_valid,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CPU_W-1:0]  reg_cpu_id,
    output sel_kind_t         sel_kind,
    output logic [CPU_W-1:0]  sel_idx
);

    logic [1:0]       region;
    logic [CPU_W-1:0] slot;
    logic             slot_in_range;
    logic             self_in_range;

    assign region        = reg_addr[ADDR_W-1 -: 2];
    assign slot          = reg_addr[3 +: CPU_W];
    assign slot_in_range = (32'(slot) < NUM_CPUS);
    assign self_in_range = (32'(reg_cpu_id) < NUM_CPUS);

    // Resolve region and slot into a selector and the mailbox it addresses.
    always_comb begin
        sel_kind = SEL_NONE;
        sel_idx  = slot;
        if (reg_valid) begin
            unique case (region)
                REG_D0:   if (slot_in_range) sel_kind = SEL_D0;
                REG_D1:   if (slot_in_range) sel_kind = SEL_D1;
                REG_BUSY: if (slot_in_range) sel_kind = SEL_BUSY;
                default: begin
                    sel_idx = reg_cpu_id;
                    if (slot == CPU_W'(ALIAS_VEC)) begin
                        sel_kind = SEL_VEC;
                    end else if (self_in_range) begin
                        if (slot == CPU_W'(ALIAS_D0))        sel_kind = SEL_D0;
                        else if (slot == CPU_W'(ALIAS_D1))   sel_kind = SEL_D1;
                        else if (slot == CPU_W'(ALIAS_BUSY)) sel_kind = SEL_BUSY;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cim_mailbox_bank.sv
// Module: cim_mailbox_bank
// One mailbox per CPU: busy flag, source identifier and two data words.
// Takes at most one accept and one status write per cycle. Assumes the
// caller never accepts into the mailbox being written. If both do arrive,
// the status write wins.
module cim_mailbox_bank #(
    parameter int NUM_CPUS = 32,
    parameter int CPU_W    = $clog2(NUM_CPUS),
    parameter int SRC_W    = 5,
    parameter int DATA_W   = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_en,
    input  logic [CPU_W-1:0]                 acc_idx,
    input  logic [SRC_W-1:0]                 acc_src,
    input  logic [DATA_W-1:0]                acc_d0,
    input  logic [DATA_W-1:0]                acc_d1,
    input  logic                             bw_en,
    input  logic [CPU_W-1:0]                 bw_idx,
    input  logic                             bw_busy,
    output logic [NUM_CPUS-1:0]              busy_q,
    output logic [NUM_CPUS-1:0][SRC_W-1:0]   src_q,
    output logic [NUM_CPUS-1:0][DATA_W-1:0]  d0_q,
    output logic [NUM_CPUS-1:0][DATA_W-1:0]  d1_q
);

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_box
        logic hit_bw;
        logic hit_acc;
        assign hit_bw  = bw_en  && (bw_idx  == CPU_W'(g));
        assign hit_acc = acc_en && (acc_idx == CPU_W'(g));

        // Update this mailbox's busy flag from a status write or an accept.
        always_ff @(posedge clk) begin
            if (!rst_n)       busy_q[g] <= 1'b0;
            else if (hit_bw)  busy_q[g] <= bw_busy;
            else if (hit_acc) busy_q[g] <= 1'b1;
        end

        // Capture this mailbox's payload when an interrupt is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[g] <= '0;
                d0_q[g]  <= '0;
                d1_q[g]  <= '0;
            end else if (hit_acc && !hit_bw) begin
                src_q[g] <= acc_src;
                d0_q[g]  <= acc_d0;
                d1_q[g]  <= acc_d1;
            end
        end
    end

endmodule

// File: rtl/cim_read_port.sv
// Module: cim_read_port
// Builds the read word for the decoded selector and registers it, so read
// data arrives one cycle after the request. Assumes SRC_W <= BUSY_BIT and
// VEC_W <= DATA_W.
module cim_read_port
    import cim_pkg::*;
#(
    parameter int NUM_CPUS = 32,
    parameter int CPU_W    = $clog2(NUM_CPUS),
    parameter int SRC_W    = 5,
    parameter int DATA_W   = 64,
    parameter int VEC_W    = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_en,
    input  sel_kind_t                        sel_kind,
    input  logic [CPU_W-1:0]                 sel_idx,
    input  logic [NUM_CPUS-1:0]              busy_q,
    input  logic [NUM_CPUS-1:0][SRC_W-1:0]   src_q,
    input  logic [NUM_CPUS-1:0][DATA_W-1:0]  d0_q,
    input  logic [NUM_CPUS-1:0][DATA_W-1:0]  d1_q,
    input  logic [VEC_W-1:0]                 vec_q,
    output logic [DATA_W-1:0]                rdata,
    output logic                             rvalid
);

    logic [DATA_W-1:0] word;

    // Pick the mailbox field or the vector named by the selector.
    always_comb begin
        word = '0;
        unique case (sel_kind)
            SEL_D0:   word = d0_q[sel_idx];
            SEL_D1:   word = d1_q[sel_idx];
            SEL_BUSY: begin
                word[BUSY_BIT]    = busy_q[sel_idx];
                word[SRC_W-1:0]   = src_q[sel_idx];
            end
            SEL_VEC:  word[VEC_W-1:0] = vec_q;
            default:  word = '0;
        endcase
    end

    // Register the read result and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rdata  <= rd_en ? word : '0;
            rvalid <= rd_en;
        end
    end

endmodule

// File: rtl/cpu_irq_mailbox.sv
// Module: cpu_irq_mailbox
// Top of the per-CPU bus interrupt mailbox. Decides accept or retry for an
// offered interrupt in the same cycle, posts the shared vector on accept,
// holds the vector register and connects decode, storage and the read port.
// Assumes one interrupt and one register access per cycle at most.
module cpu_irq_mailbox
    import cim_pkg::*;
#(
    parameter int NUM_CPUS = 32,
    parameter int DATA_W   = 64,
    parameter int SRC_W    = 5,
    parameter int VEC_W    = 6,
    localparam int CPU_W   = $clog2(NUM_CPUS),
    localparam int ADDR_W  = CPU_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_valid,
    input  logic [CPU_W-1:0]  irq_cpu,
    input  logic [SRC_W-1:0]  irq_src,
    input  logic [DATA_W-1:0] irq_data0,
    input  logic [DATA_W-1:0] irq_data1,
    output logic              irq_accept,
    output logic              irq_retry,
    output logic              post_valid,
    output logic [CPU_W-1:0]  post_cpu,
    output logic [VEC_W-1:0]  post_vector,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CPU_W-1:0]  reg_cpu_id,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid
);

    sel_kind_t                       sel_kind;
    logic [CPU_W-1:0]                sel_idx;
    logic                            bw_en;
    logic [CPU_W-1:0]                bw_idx;
    logic                            rd_en;
    logic                            target_ok;
    logic                            clash;
    logic [NUM_CPUS-1:0]             busy_q;
    logic [NUM_CPUS-1:0][SRC_W-1:0]  src_q;
    logic [NUM_CPUS-1:0][DATA_W-1:0] d0_q;
    logic [NUM_CPUS-1:0][DATA_W-1:0] d1_q;
    logic [VEC_W-1:0]                vec_q;

    cim_reg_decode #(
        .NUM_CPUS (NUM_CPUS),
        .CPU_W    (CPU_W),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .reg_valid  (reg_valid),
        .reg_addr   (reg_addr),
        .reg_cpu_id (reg_cpu_id),
        .sel_kind   (sel_kind),
        .sel_idx    (sel_idx)
    );

    assign bw_en  = reg_write && (sel_kind == SEL_BUSY);
    assign bw_idx = sel_idx;
    assign rd_en  = reg_valid && !reg_write;

    // Same-cycle arbitration: a status write to the target mailbox wins.
    always_comb begin
        target_ok  = (32'(irq_cpu) < NUM_CPUS);
        clash      = bw_en && (bw_idx == irq_cpu);
        irq_accept = irq_valid && target_ok && !busy_q[irq_cpu] && !clash;
        irq_retry  = irq_valid && !irq_accept;
    end

    assign post_valid  = irq_accept;
    assign post_cpu    = irq_cpu;
    assign post_vector = vec_q;

    // Shared vector register, loaded from the low data bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (reg_write && (sel_kind == SEL_VEC))
            vec_q <= reg_wdata[VEC_W-1:0];
    end

    cim_mailbox_bank #(
        .NUM_CPUS (NUM_CPUS),
        .CPU_W    (CPU_W),
        .SRC_W    (SRC_W),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (irq_accept),
        .acc_idx (irq_cpu),
        .acc_src (irq_src),
        .acc_d0  (irq_data0),
        .acc_d1  (irq_data1),
        .bw_en   (bw_en),
        .bw_idx  (bw_idx),
        .bw_busy (reg_wdata[BUSY_BIT]),
        .busy_q  (busy_q),
        .src_q   (src_q),
        .d0_q    (d0_q),
        .d1_q    (d1_q)
    );

    cim_read_port #(
        .NUM_CPUS (NUM_CPUS),
        .CPU_W    (CPU_W),
        .SRC_W    (SRC_W),
        .DATA_W   (DATA_W),
        .VEC_W    (VEC_W)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel_kind (sel_kind),
        .sel_idx  (sel_idx),
        .busy_q   (busy_q),
        .src_q    (src_q),
        .d0_q     (d0_q),
        .d1_q     (d1_q),
        .vec_q    (vec_q),
        .rdata    (reg_rdata),
        .rvalid   (reg_rvalid)
    );

endmodule

// File: rtl/cim_mailbox_checker.sv
// Module: cim_mailbox_checker
// Timing and handshake properties of the mailbox, attached to the top
// module by the bind statement at the end of this file.
module cim_mailbox_checker #(
    parameter int NUM_CPUS = 32,
    parameter int CPU_W    = $clog2(NUM_CPUS),
    parameter int VEC_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_valid,
    input logic [CPU_W-1:0]    irq_cpu,
    input logic                irq_accept,
    input logic                irq_retry,
    input logic                post_valid,
    input logic                reg_valid,
    input logic                reg_write,
    input logic                reg_rvalid,
    input logic                bw_en,
    input logic [CPU_W-1:0]    bw_idx,
    input logic [NUM_CPUS-1:0] busy_q,
    input logic [VEC_W-1:0]    vec_q
);

    // R2: an offered interrupt gets exactly one answer
    a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_accept != irq_retry));

    // R2: nothing offered, nothing answered or posted
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (!irq_accept && !irq_retry && !post_valid));

    // R3: a busy mailbox refuses
    a_r3_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && busy_q[irq_cpu]) |-> irq_retry);

    // R4: an accept leaves the target busy
    a_r4_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> busy_q[$past(irq_cpu)]);

    // R5: a status write to the target mailbox forces a retry
    a_r5_clash_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && bw_en && (bw_idx == irq_cpu)) |-> irq_retry);

    // R6: the vector holds unless software writes
    a_r6_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && reg_write) |=> $stable(vec_q));

    // R9: busy flags move only through an accept or a status write
    a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_accept && !bw_en) |=> $stable(busy_q));

    // R10: read data valid one cycle after a read request
    a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |=> reg_rvalid);

    // R10: no valid strobe without a read request
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && !reg_write) |=> !reg_rvalid);

endmodule

bind cpu_irq_mailbox cim_mailbox_checker #(
    .NUM_CPUS (NUM_CPUS),
    .CPU_W    (CPU_W),
    .VEC_W    (VEC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_valid  (irq_valid),
    .irq_cpu    (irq_cpu),
    .irq_accept (irq_accept),
    .irq_retry  (irq_retry),
    .post_valid (post_valid),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_rvalid (reg_rvalid),
    .bw_en      (bw_en),
    .bw_idx     (bw_idx),
    .busy_q     (busy_q),
    .vec_q      (vec_q)
);

// File: tb/cpu_irq_mailbox_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, all checked
// against a reference model kept in bench variables.
module cpu_irq_mailbox_test;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_valid = 1'b0;
    logic [4:0]  irq_cpu = '0;
    logic [4:0]  irq_src = '0;
    logic [63:0] irq_data0 = '0;
    logic [63:0] irq_data1 = '0;
    logic        irq_accept, irq_retry, post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vector;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [4:0]  reg_cpu_id = '0;
    logic [63:0] reg_rdata;
    logic        reg_rvalid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Reference model
    bit          m_busy [N];
    logic [4:0]  m_src  [N];
    logic [63:0] m_d0   [N];
    logic [63:0] m_d1   [N];
    logic [5:0]  m_vec;

    always #2.5 clk = ~clk;

    cpu_irq_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .irq_valid(irq_valid), .irq_cpu(irq_cpu), .irq_src(irq_src),
        .irq_data0(irq_data0), .irq_data1(irq_data1),
        .irq_accept(irq_accept), .irq_retry(irq_retry),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vector(post_vector),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_cpu_id(reg_cpu_id),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected read word from the model (R6, R7, R8, R10)
    function automatic logic [63:0] exp_read(input logic [9:0] a, input logic [4:0] cid);
        logic [1:0] rg = a[9:8];
        logic [4:0] sl = a[7:3];
        logic [4:0] ix = (rg == 2'd3) ? cid : sl;
        logic [63:0] w = '0;
        if (rg == 2'd0 || (rg == 2'd3 && sl == 5'd0)) w = m_d0[ix];
        else if (rg == 2'd1 || (rg == 2'd3 && sl == 5'd1)) w = m_d1[ix];
        else if (rg == 2'd2 || (rg == 2'd3 && sl == 5'd2)) begin
            w[5] = m_busy[ix];
            w[4:0] = m_src[ix];
        end else if (rg == 2'd3 && sl == 5'd3) w[5:0] = m_vec;
        return w;
    endfunction

    function automatic string read_tag(input logic [9:0] a);
        if (a[9:8] != 2'd3) return "R7";
        if (a[7:3] <= 5'd2) return "R8";
        if (a[7:3] == 5'd3) return "R6";
        return "R10";
    endfunction

    // Status-write target, or -1 when the access writes no status register
    function automatic int busy_target(input bit rv, input bit rw,
                                       input logic [9:0] a, input logic [4:0] cid);
        if (!(rv && rw)) return -1;
        if (a[9:8] == 2'd2) return int'(a[7:3]);
        if (a[9:8] == 2'd3 && a[7:3] == 5'd2) return int'(cid);
        return -1;
    endfunction

    // One clock cycle: drive at the falling edge, check the same-cycle
    // answer, model the rising edge, check read data at the next falling edge.
    task automatic step(input bit iv, input logic [4:0] ic, input logic [4:0] is,
                        input logic [63:0] i0, input logic [63:0] i1,
                        input bit rv, input bit rw, input logic [9:0] ra,
                        input logic [63:0] wd, input logic [4:0] rc,
                        input string tag);
        int bt;
        bit exp_acc;
        logic [63:0] exp_rd;
        string t;
        irq_valid = iv; irq_cpu = ic; irq_src = is; irq_data0 = i0; irq_data1 = i1;
        reg_valid = rv; reg_write = rw; reg_addr = ra; reg_wdata = wd; reg_cpu_id = rc;
        #1;
        bt = busy_target(rv, rw, ra, rc);
        exp_acc = iv && !m_busy[ic] && (bt != int'(ic));
        if (!iv) t = "R2";
        else if (m_busy[ic]) t = "R3";
        else if (bt == int'(ic)) t = "R5";
        else t = "R2";
        if (tag != "") t = tag;
        chk(irq_accept == exp_acc, t, "irq_accept", 64'(irq_accept), 64'(exp_acc));
        chk(irq_retry == (iv && !exp_acc), t, "irq_retry", 64'(irq_retry), 64'(iv && !exp_acc));
        chk(post_valid == exp_acc, t, "post_valid", 64'(post_valid), 64'(exp_acc));
        if (exp_acc) begin
            chk(post_cpu == ic, "R2", "post_cpu", 64'(post_cpu), 64'(ic));
            chk(post_vector == m_vec, "R2", "post_vector", 64'(post_vector), 64'(m_vec));
        end
        exp_rd = exp_read(ra, rc);
        @(posedge clk);
        if (exp_acc) begin
            m_busy[ic] = 1'b1; m_src[ic] = is; m_d0[ic] = i0; m_d1[ic] = i1;
        end
        if (bt >= 0) m_busy[bt] = wd[5];
        if (rv && rw && ra[9:8] == 2'd3 && ra[7:3] == 5'd3) m_vec = wd[5:0];
        @(negedge clk);
        t = (tag != "") ? tag : read_tag(ra);
        if (rv && !rw) begin
            chk(reg_rvalid == 1'b1, "R10", "reg_rvalid", 64'(reg_rvalid), 64'd1);
            chk(reg_rdata == exp_rd, t, "reg_rdata", reg_rdata, exp_rd);
        end else begin
            chk(reg_rvalid == 1'b0, "R10", "reg_rvalid idle", 64'(reg_rvalid), 64'd0);
        end
    endtask

    task automatic rd(input logic [9:0] a, input logic [4:0] cid, input string tag);
        step(0, '0, '0, '0, '0, 1, 0, a, '0, cid, tag);
    endtask

    task automatic wr(input logic [9:0] a, input logic [63:0] d, input logic [4:0] cid, input string tag);
        step(0, '0, '0, '0, '0, 1, 1, a, d, cid, tag);
    endtask

    task automatic irq(input logic [4:0] c, input logic [4:0] s, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
        step(1, c, s, a, b, 0, 0, '0, '0, '0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_src[i] = '0; m_d0[i] = '0; m_d1[i] = '0;
        end
        m_vec = '0;
        repeat (4) @(negedge clk);
        chk(reg_rvalid == 1'b0, "R1", "rvalid in reset", 64'(reg_rvalid), 64'd0);
        rst_n = 1'b1;

        // R1: reset state
        rd(10'h318, 5'd0, "R1");
        rd(10'h200, 5'd0, "R1");
        rd(10'h028, 5'd0, "R1");
        rd(10'h310, 5'd9, "R1");

        // R6: vector write keeps only bits 5:0
        wr(10'h318, 64'hFFFF_FFC0 | 64'h2A, 5'd0, "R6");
        rd(10'h318, 5'd0, "R6");

        // R2/R4: accept into cpu 3, then read its slots
        irq(5'd3, 5'd17, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, "R2");
        rd(10'h218, 5'd0, "R4");
        rd(10'h018, 5'd0, "R4");
        rd(10'h118, 5'd0, "R4");

        // R3: busy mailbox refuses; contents unchanged
        irq(5'd3, 5'd2, 64'h5, 64'h6, "R3");
        rd(10'h018, 5'd0, "R3");
        rd(10'h218, 5'd0, "R3");

        // R8: alias slots with requester 3
        rd(10'h300, 5'd3, "R8");
        rd(10'h308, 5'd3, "R8");
        rd(10'h310, 5'd3, "R8");

        // R9: data writes ignored; busy write keeps source
        wr(10'h018, 64'hDEAD, 5'd0, "R9");
        rd(10'h018, 5'd0, "R9");
        wr(10'h218, 64'h1F, 5'd0, "R9");
        rd(10'h218, 5'd0, "R9");
        wr(10'h3F8, 64'h3F, 5'd0, "R9");
        rd(10'h318, 5'd0, "R9");

        // R5: collision via indexed slot and via alias slot
        step(1, 5'd7, 5'd4, 64'h7, 64'h8, 1, 1, 10'h238, 64'h0, 5'd0, "R5");
        rd(10'h238, 5'd0, "R5");
        step(1, 5'd9, 5'd4, 64'h9, 64'hA, 1, 1, 10'h310, 64'h20, 5'd9, "R5");
        rd(10'h248, 5'd0, "R5");

        // R9: software sets busy, then releases through the alias slot
        wr(10'h240, 64'h20, 5'd0, "R9");
        irq(5'd8, 5'd1, 64'h1, 64'h2, "R9");
        wr(10'h310, 64'h0, 5'd8, "R9");
        irq(5'd8, 5'd1, 64'h1, 64'h2, "R9");
        rd(10'h248 - 10'h8, 5'd0, "R9");

        // R10: unmapped offset reads 0
        rd(10'h320, 5'd0, "R10");
        rd(10'h3E0, 5'd0, "R10");

        // Random traffic concentrated on a few mailboxes
        for (int n = 0; n < 4000; n++) begin
            bit iv = ($urandom % 2) == 0;
            logic [4:0] ic = (($urandom % 8) == 0) ? 5'($urandom) : 5'($urandom % 4);
            int op = $urandom % 9;
            bit rv = 1, rw = 0;
            logic [9:0] ra = '0;
            logic [63:0] wd = {$urandom, $urandom};
            logic [4:0] rc = 5'($urandom % 4);
            logic [4:0] tc = (($urandom % 2) == 0) ? ic : 5'($urandom % 4);
            case (op)
                0: begin rw = 1; ra = {2'd2, tc, 3'($urandom)};
                         wd[5] = (($urandom % 4) == 0); end
                1: begin rw = 1; ra = 10'h310; rc = tc;
                         wd[5] = (($urandom % 4) == 0); end
                2, 3: ra = {2'($urandom % 3), 5'($urandom % 4), 3'd0};
                4: ra = {2'd3, 5'($urandom % 3), 3'd0};
                5: begin rw = 1; ra = 10'h318; end
                6: ra = 10'h318;
                7: begin rw = 1; ra = 10'($urandom); end
                default: rv = 0;
            endcase
            step(iv, ic, 5'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                 rv, rw, ra, wd, rc, "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule